// File: doc/BRIEF.md
# Indexed Host Register Window for a Dual-Channel ISDN Adapter

This block is the host-facing register front end of a two-channel ISDN line adapter. The host sees a 32-byte I/O window. The upper half of that window is a shared data port. An index latch, written at a fixed offset, decides which internal unit the data port reaches. The five possible units are the two HDLC channels, the line transceiver FIFO, and the low and high register banks of the line transceiver. Accesses made while the latch holds a code that names no unit go nowhere and read back as zero.

The lower half of the window holds three more registers. A status/control register returns three active-low interrupt source lines when read. When written, it drives the adapter reset, the timer disable, the timer reset, the interrupt enable and a test bit. A second register selects the interrupt line and enables the serial line-interface bus.

A three-state mode machine follows the last control write. The state is QUIET after a write of zero, HELD while reset is asserted, and RUN otherwise. The aggregated interrupt output goes high only when interrupts are enabled and at least one source is pending.

Top module: `isdn_host_window`

## Requirements
- R1: After reset, the index latch holds 0, so `tgt_sel` is 5'b00001. `irq_out`, `dev_reset`, `timer_dis`, `timer_clr`, `test_bit`, `irq_sel` and `line_bus_en` are all 0, and `dev_mode` is 0 (QUIET).
- R2: A write to offset 0x04 stores `wdata[2:0]` in the index latch. Code 0 sets `tgt_sel` bit0 (HDLC channel 1). Code 1 sets bit1 (HDLC channel 2). Code 2 sets bit2 (transceiver FIFO). Code 4 sets bit3 (low transceiver bank). Code 6 sets bit4 (high transceiver bank). Codes 3, 5 and 7 select nothing (`tgt_sel` = 0).
- R3: The index latch keeps its value until offset 0x04 is written again. A read of offset 0x04 returns {5'b0, latch}.
- R4: Offsets 0x10 to 0x1F form the data window. `win_addr` carries the low 4 address bits. `win_wr` and `win_rd` pulse in the same cycle as the host strobe, but only while a unit is selected. A read returns `win_rdata` while a unit is selected, and 0x00 otherwise.
- R5: A read of offset 0x02 returns {5'b0, `src_timer_n`, `src_hdlc_n`, `src_xcvr_n`}. Each source is active-low, so 3'b111 means nothing is pending.
- R6: A write to offset 0x02 takes effect one clock later. Bit0 drives `dev_reset`, bit1 `timer_dis`, bit2 `timer_clr`, bit3 the interrupt enable and bit4 `test_bit`.
- R7: One clock after any change, `irq_out` equals the interrupt enable ANDed with "at least one source line is low". With all three sources high, it is 0.
- R8: A write to offset 0x03 sets `irq_sel` from bits 3:0 and `line_bus_en` from bit7. A read of offset 0x03 returns {`line_bus_en`, 3'b0, `irq_sel`}.
- R9: A read of any other offset returns 0x00. A write to any other offset changes no register.
- R10: `dev_mode` follows the last write to offset 0x02. It is 0 (QUIET) for a value of zero, 1 (HELD) when bit0 is set, and 2 (RUN) otherwise. Transitions are QUIET→HELD, HELD→RUN, RUN→QUIET and so on, each taken on the write that selects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte offset within the window |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data (combinational) |
| win_rdata | input | 8 | Read data from the selected unit |
| win_addr | output | 4 | Address within the selected unit |
| win_wdata | output | 8 | Write data to the selected unit |
| win_wr | output | 1 | Write strobe to the selected unit |
| win_rd | output | 1 | Read strobe to the selected unit |
| tgt_sel | output | 5 | One-hot unit select from the index latch |
| src_xcvr_n | input | 1 | Transceiver interrupt, active-low |
| src_hdlc_n | input | 1 | HDLC interrupt, active-low |
| src_timer_n | input | 1 | Timer interrupt, active-low |
| irq_out | output | 1 | Aggregated interrupt request |
| dev_reset | output | 1 | Adapter reset |
| timer_dis | output | 1 | Timer disable |
| timer_clr | output | 1 | Timer reset |
| test_bit | output | 1 | Test bit |
| irq_sel | output | 4 | Interrupt line select |
| line_bus_en | output | 1 | Line-interface bus enable |
| dev_mode | output | 2 | Mode state: 0 QUIET, 1 HELD, 2 RUN |

## Verification
Several properties are checked on every cycle:
- The unit select is never more than one-hot.
- A data-window strobe appears only when a unit is selected and the host strobe is in the window.
- The index select changes only after an index write.
- `irq_out` is never raised when the sources were all high one cycle earlier, and never raised when `dev_mode` was QUIET.

Some behaviours can only be shown by the bench's scenarios: the exact code-to-unit mapping, register readback values, zero reads from unmapped offsets and from a window with no unit selected, and the full QUIET/HELD/RUN path.

// File: rtl/hw_pkg.sv
package hw_pkg;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 8;
    localparam int IDX_W    = 3;
    localparam int N_TGT    = 5;
    localparam int N_SRC    = 3;
    localparam int OFF_CTL  = 2;
    localparam int OFF_LINE = 3;
    localparam int OFF_IDX  = 4;
    localparam int WIN_BASE = 16;

    typedef enum logic [1:0] {
        MODE_QUIET = 2'd0,
        MODE_HELD  = 2'd1,
        MODE_RUN   = 2'd2
    } mode_e;

    // index code owned by each one-hot target position
    function automatic logic [IDX_W-1:0] tgt_code(input int t);
        case (t)
            0: tgt_code = 3'd0;
            1: tgt_code = 3'd1;
            2: tgt_code = 3'd2;
            3: tgt_code = 3'd4;
            default: tgt_code = 3'd6;
        endcase
    endfunction
endpackage

// File: rtl/hw_index_decode.sv
module hw_index_decode
    import hw_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int NT = N_TGT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_we,
    input  logic [IW-1:0] idx_wdata,
    output logic [IW-1:0] idx_q,
    output logic [NT-1:0] sel
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_we) idx_q <= idx_wdata;
    end

    for (genvar t = 0; t < NT; t++) begin : g_tgt
        assign sel[t] = (idx_q == tgt_code(t));
    end
endmodule

// File: rtl/hw_irq_agg.sv
module hw_irq_agg
    import hw_pkg::*;
#(
    parameter int NS = N_SRC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_en,
    input  logic [NS-1:0] src_n,
    output logic          irq_q
);
    logic pending;
    assign pending = ~(&src_n);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_en & pending;
    end
endmodule

// File: rtl/hw_ctl_fsm.sv
module hw_ctl_fsm
    import hw_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic          line_we,
    input  logic [DW-1:0] wdata,
    output logic          dev_reset,
    output logic          timer_dis,
    output logic          timer_clr,
    output logic          irq_en,
    output logic          test_bit,
    output logic [3:0]    irq_sel,
    output logic          line_bus_en,
    output mode_e         mode
);
    logic [4:0] ctl_q;
    logic [4:0] line_q;
    mode_e      state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            line_q <= '0;
        end else begin
            if (ctl_we)  ctl_q  <= wdata[4:0];
            if (line_we) line_q <= {wdata[7], wdata[3:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (ctl_we) begin
            if (wdata[0])              state_d = MODE_HELD;
            else if (wdata[4:0] == '0) state_d = MODE_QUIET;
            else                       state_d = MODE_RUN;
        end
    end

    always_comb begin
        mode      = state_q;
        dev_reset = 1'b0;
        unique case (state_q)
            MODE_QUIET: dev_reset = 1'b0;
            MODE_HELD:  dev_reset = 1'b1;
            MODE_RUN:   dev_reset = 1'b0;
            default:    dev_reset = 1'b0;
        endcase
        timer_dis   = ctl_q[1];
        timer_clr   = ctl_q[2];
        irq_en      = ctl_q[3] & (state_q != MODE_QUIET);
        test_bit    = ctl_q[4];
        irq_sel     = line_q[3:0];
        line_bus_en = line_q[4];
    end
endmodule

// File: rtl/isdn_host_window.sv
module isdn_host_window
    import hw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] win_rdata,
    output logic [3:0]        win_addr,
    output logic [DATA_W-1:0] win_wdata,
    output logic              win_wr,
    output logic              win_rd,
    output logic [N_TGT-1:0]  tgt_sel,
    input  logic              src_xcvr_n,
    input  logic              src_hdlc_n,
    input  logic              src_timer_n,
    output logic              irq_out,
    output logic              dev_reset,
    output logic              timer_dis,
    output logic              timer_clr,
    output logic              test_bit,
    output logic [3:0]        irq_sel,
    output logic              line_bus_en,
    output logic [1:0]        dev_mode
);
    localparam int WIN_HI = WIN_BASE >> 4;

    logic             hit_win, hit_ctl, hit_line, hit_idx, any_tgt, irq_en;
    logic [IDX_W-1:0] idx_q;
    logic [N_SRC-1:0] src_n;
    mode_e            mode;

    assign hit_win  = (bus_addr >> 4) == ADDR_W'(WIN_HI);
    assign hit_ctl  = bus_addr == ADDR_W'(OFF_CTL);
    assign hit_line = bus_addr == ADDR_W'(OFF_LINE);
    assign hit_idx  = bus_addr == ADDR_W'(OFF_IDX);
    assign src_n    = {src_timer_n, src_hdlc_n, src_xcvr_n};
    assign any_tgt  = |tgt_sel;

    hw_index_decode u_idx (
        .clk(clk), .rst_n(rst_n),
        .idx_we(bus_wr & hit_idx), .idx_wdata(bus_wdata[IDX_W-1:0]),
        .idx_q(idx_q), .sel(tgt_sel)
    );

    hw_ctl_fsm u_ctl (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(bus_wr & hit_ctl), .line_we(bus_wr & hit_line),
        .wdata(bus_wdata),
        .dev_reset(dev_reset), .timer_dis(timer_dis), .timer_clr(timer_clr),
        .irq_en(irq_en), .test_bit(test_bit), .irq_sel(irq_sel),
        .line_bus_en(line_bus_en), .mode(mode)
    );

    hw_irq_agg u_irq (
        .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .src_n(src_n), .irq_q(irq_out)
    );

    assign dev_mode  = mode;
    assign win_addr  = bus_addr[3:0];
    assign win_wdata = bus_wdata;
    assign win_wr    = bus_wr & hit_win & any_tgt;
    assign win_rd    = bus_rd & hit_win & any_tgt;

    always_comb begin
        bus_rdata = '0;
        if (hit_win)       bus_rdata = any_tgt ? win_rdata : '0;
        else if (hit_ctl)  bus_rdata = {{(DATA_W-N_SRC){1'b0}}, src_n};
        else if (hit_line) bus_rdata = {line_bus_en, 3'b000, irq_sel};
        else if (hit_idx)  bus_rdata = {{(DATA_W-IDX_W){1'b0}}, idx_q};
    end
endmodule

// File: rtl/hw_window_chk.sv
module hw_window_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic       win_wr,
    input logic       win_rd,
    input logic [4:0] tgt_sel,
    input logic [2:0] src_n,
    input logic       irq_out,
    input logic [1:0] dev_mode
);
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_sel)); // R2
    AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        win_wr |-> (bus_wr && bus_addr[4] && tgt_sel != 5'd0)); // R4
    AST_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        win_rd |-> (bus_rd && bus_addr[4] && tgt_sel != 5'd0)); // R4
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 5'd4) |=> $stable(tgt_sel)); // R3
    AST_NO_SRC_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (&src_n) |=> !irq_out); // R7
    AST_QUIET_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_mode == 2'd0) |=> !irq_out); // R10
endmodule

bind isdn_host_window hw_window_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .win_wr(win_wr), .win_rd(win_rd), .tgt_sel(tgt_sel),
    .src_n({src_timer_n, src_hdlc_n, src_xcvr_n}), .irq_out(irq_out),
    .dev_mode(dev_mode)
);

// File: tb/sim_isdn_host_window.sv
module sim_isdn_host_window;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata, win_rdata = 8'hA5, win_wdata;
    logic [3:0] win_addr, irq_sel;
    logic       win_wr, win_rd, irq_out, dev_reset, timer_dis, timer_clr, test_bit, line_bus_en;
    logic [4:0] tgt_sel;
    logic [1:0] dev_mode;
    logic       sx = 1'b1, sh = 1'b1, st = 1'b1;
    int         n_chk = 0, n_bad = 0;

    // {index code, expected one-hot select}
    localparam logic [15:0] IDX_VEC [8] = '{
        {8'd0, 8'h01}, {8'd1, 8'h02}, {8'd2, 8'h04}, {8'd3, 8'h00},
        {8'd4, 8'h08}, {8'd5, 8'h00}, {8'd6, 8'h10}, {8'd7, 8'h00}
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    isdn_host_window u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .win_rdata(win_rdata), .win_addr(win_addr), .win_wdata(win_wdata),
        .win_wr(win_wr), .win_rd(win_rd), .tgt_sel(tgt_sel),
        .src_xcvr_n(sx), .src_hdlc_n(sh), .src_timer_n(st), .irq_out(irq_out),
        .dev_reset(dev_reset), .timer_dis(timer_dis), .timer_clr(timer_clr),
        .test_bit(test_bit), .irq_sel(irq_sel), .line_bus_en(line_bus_en),
        .dev_mode(dev_mode)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 sel", tgt_sel, 5'b00001);
        check("R1 ctl", {irq_out, dev_reset, timer_dis, timer_clr, test_bit, line_bus_en, irq_sel}, 0);
        check("R1 mode", dev_mode, 0);

        // R2 table of index codes
        for (int i = 0; i < 8; i++) begin
            wr(5'h04, IDX_VEC[i][15:8]);
            check("R2 sel", tgt_sel, IDX_VEC[i][4:0]);
            rd(5'h04, d);
            check("R3 readback", d, IDX_VEC[i][15:8]);
        end

        // R4 window with no unit (code 7 latched)
        rd(5'h13, d);
        check("R4 empty read", d, 8'h00);
        @(negedge clk); bus_addr = 5'h15; bus_wr = 1'b1; #1;
        check("R4 gated wr", win_wr, 1'b0);
        @(negedge clk); bus_wr = 1'b0;
        // R4 window with high bank
        wr(5'h04, 8'h06);
        @(negedge clk); bus_addr = 5'h1B; bus_rd = 1'b1; #1;
        check("R4 win_rd", {win_rd, win_addr}, {1'b1, 4'hB});
        check("R4 rdata", bus_rdata, 8'hA5);
        @(negedge clk); bus_rd = 1'b0;
        // R3 hold across other traffic
        wr(5'h03, 8'h85); wr(5'h12, 8'h33);
        check("R3 hold", tgt_sel, 5'b10000);
        // R8
        rd(5'h03, d);
        check("R8 readback", d, 8'h85);
        check("R8 ports", {line_bus_en, irq_sel}, {1'b1, 4'h5});
        // R9 unmapped
        wr(5'h05, 8'hFF); wr(5'h00, 8'hFF);
        rd(5'h05, d); check("R9 read 05", d, 8'h00);
        rd(5'h01, d); check("R9 read 01", d, 8'h00);
        rd(5'h03, d); check("R9 no change", d, 8'h85);
        check("R9 idx", tgt_sel, 5'b10000);
        // R5 status
        sh = 1'b0;
        rd(5'h02, d); check("R5 status", d, 8'h05);
        sh = 1'b1;
        rd(5'h02, d); check("R5 idle", d, 8'h07);
        // R10/R6 HELD
        wr(5'h02, 8'h03);
        check("R10 held", dev_mode, 1);
        check("R6 held", {dev_reset, timer_dis}, 2'b11);
        // R6/R10 RUN with enable
        wr(5'h02, 8'h1E);
        check("R10 run", dev_mode, 2);
        check("R6 bits", {test_bit, timer_clr, timer_dis, dev_reset}, 4'b1110);
        // R7 irq
        check("R7 no src", irq_out, 1'b0);
        @(negedge clk); st = 1'b0;
        @(negedge clk);
        check("R7 timer", irq_out, 1'b1);
        st = 1'b1;
        @(negedge clk);
        check("R7 clear", irq_out, 1'b0);
        // R7 disabled enable
        wr(5'h02, 8'h06);
        sx = 1'b0;
        @(negedge clk);
        check("R7 masked", irq_out, 1'b0);
        sx = 1'b1;
        // R10 QUIET
        wr(5'h02, 8'h00);
        check("R10 quiet", {dev_mode, timer_dis, timer_clr}, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule